// File: doc/BRIEF.md
# Workweek Remaining-Time Countdown

This block keeps a free-running weekly clock of day of week, hour, minute and second. From that clock it derives how much of the working week is left and presents the result as separate days, hours, minutes and seconds fields. The working week opens on Monday at 09:00:00 and closes on Friday at 17:00:00. Outside that window a weekend flag is raised and the countdown fields read zero.

The clock advances on a tick enable. `TICKS_PER_SEC` tick pulses make one second. A set strobe loads the current day and time in a single cycle. After that the block runs without supervision. Display decoding, oscillator division, debouncing and calendar dates belong to other blocks.

Top module: `wk_countdown`

## Requirements
- R1: After reset, the clock reads Monday 00:00:00 (day 0, hour 0, minute 0, second 0). The weekend flag is 1 and all countdown fields are 0.
- R2: The clock field encodings are:
  - day 0..6, where 0 is Monday and 4 is Friday;
  - hour 0..23;
  - minute 0..59;
  - second 0..59.

  Every `TICKS_PER_SEC`-th tick pulse advances the clock by one second. Carries ripple from second to minute to hour to day, and day 6 wraps to day 0.
- R3: A set strobe with in-range fields loads day, hour, minute and second in one cycle. It takes priority over a tick in the same cycle and clears the count of tick pulses within the current second.
- R4: A set strobe with any field out of range (day above 6, hour above 23, minute or second above 59) is ignored. The clock and the count of tick pulses within the second are unchanged.
- R5: While the clock is inside the working-week window, the countdown fields give the time left until Friday 17:00:00. Seconds and minutes lie in 0..59, hours in 0..23, and the weekend flag is 0.
- R6: At Monday 09:00:00 the countdown reads 4 days, 8 hours, 0 minutes, 0 seconds. At Monday 08:59:59 the weekend flag is still 1.
- R7: At Friday 16:59:59 the countdown reads 0 days, 0 hours, 0 minutes, 1 second. From Friday 17:00:00 the weekend flag is 1 and every countdown field is 0.
- R8: The clock and countdown outputs are registered. They change on the clock edge that samples the tick or set, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Tick pulse; `TICKS_PER_SEC` pulses make one second |
| set_en | input | 1 | Load strobe for the set fields |
| set_day | input | 3 | Day of week to load (0 = Monday) |
| set_hr | input | 5 | Hour to load |
| set_min | input | 6 | Minute to load |
| set_sec | input | 6 | Second to load |
| cur_day | output | 3 | Current day of week |
| cur_hr | output | 5 | Current hour |
| cur_min | output | 6 | Current minute |
| cur_sec | output | 6 | Current second |
| rem_day | output | 3 | Days left in the working week |
| rem_hr | output | 5 | Hours left |
| rem_min | output | 6 | Minutes left |
| rem_sec | output | 6 | Seconds left |
| weekend | output | 1 | High outside the working-week window |

## Verification
Directed loads just before the window edges are stepped across with ticks:
- Monday 08:59:59 checks the opening instant.
- Friday 16:59:59 checks the closing instant.
- Sunday 23:59:59 checks the wrap from day 6 to day 0.
- Clock values with every field at its maximum check that the carries ripple through all fields.

Random loads that favour seconds and minutes near 59, mixed with random ticks, spread the borrow arithmetic of the countdown across the whole week. The bench compares it against a reference that counts seconds of the week and divides, which tells field-wise borrow errors apart from window-edge errors. Three further patterns each separate one behaviour:
- A set in the same cycle as a tick shows whether the load has priority.
- Out-of-range sets placed between tick pulses show whether the pulse count survives a rejected load.
- Probing just before a sampling edge shows that the outputs are registered.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    localparam int DAY_W = 3;
    localparam int HR_W  = 5;
    localparam int MIN_W = 6;
    localparam int SEC_W = 6;

    localparam int DAYS  = 7;
    localparam int HOURS = 24;
    localparam int MINS  = 60;
    localparam int SECS  = 60;

    localparam int OPEN_DAY  = 0;
    localparam int OPEN_HR   = 9;
    localparam int CLOSE_DAY = 4;
    localparam int CLOSE_HR  = 17;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } wk_time_t;

    typedef struct packed {
        logic     off;
        wk_time_t left;
    } wk_remain_t;

    function automatic logic time_ok(wk_time_t t);
        return (int'(t.day) < DAYS) && (int'(t.hr) < HOURS) &&
               (int'(t.mn) < MINS) && (int'(t.sc) < SECS);
    endfunction

    function automatic wk_time_t advance(wk_time_t t);
        wk_time_t n;
        n = t;
        if (int'(t.sc) == SECS - 1) begin
            n.sc = '0;
            if (int'(t.mn) == MINS - 1) begin
                n.mn = '0;
                if (int'(t.hr) == HOURS - 1) begin
                    n.hr = '0;
                    if (int'(t.day) == DAYS - 1) n.day = '0;
                    else                         n.day = t.day + 1'b1;
                end else begin
                    n.hr = t.hr + 1'b1;
                end
            end else begin
                n.mn = t.mn + 1'b1;
            end
        end else begin
            n.sc = t.sc + 1'b1;
        end
        return n;
    endfunction

    function automatic logic in_window(wk_time_t t);
        int d;
        int h;
        d = int'(t.day);
        h = int'(t.hr);
        return (d > OPEN_DAY && d < CLOSE_DAY) ||
               (d == OPEN_DAY && h >= OPEN_HR) ||
               (d == CLOSE_DAY && h < CLOSE_HR);
    endfunction

    // Field-wise subtraction of t from the closing instant, borrowing upward.
    function automatic wk_remain_t remaining(wk_time_t t);
        wk_remain_t r;
        int bs;
        int mm;
        int bm;
        int hh;
        int bh;
        r = '0;
        if (!in_window(t)) begin
            r.off = 1'b1;
        end else begin
            bs = (t.sc != '0) ? 1 : 0;
            r.left.sc = SEC_W'((bs != 0) ? (SECS - int'(t.sc)) : 0);
            mm = int'(t.mn) + bs;
            bm = (mm != 0) ? 1 : 0;
            r.left.mn = MIN_W'((bm != 0) ? (MINS - mm) : 0);
            hh = int'(t.hr) + bm;
            if (hh <= CLOSE_HR) begin
                r.left.hr = HR_W'(CLOSE_HR - hh);
                bh = 0;
            end else begin
                r.left.hr = HR_W'(CLOSE_HR + HOURS - hh);
                bh = 1;
            end
            r.left.day = DAY_W'(CLOSE_DAY - int'(t.day) - bh);
        end
        return r;
    endfunction

endpackage

// File: rtl/wkc_phase.sv
module wkc_phase #(
    parameter int TICKS_PER_SEC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic load,
    output logic sec_pulse
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign sec_pulse = tick_en & ~load;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
            logic [CW-1:0] cnt_q;

            assign sec_pulse = tick_en && !load && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || load) begin
                    cnt_q <= '0;
                end else if (tick_en) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            // R2
            phase_range_chk: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST);

            // R3
            phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
                load |=> cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/wkc_clock.sv
module wkc_clock
    import wkc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  wk_time_t load_t,
    input  logic     sec_pulse,
    output wk_time_t now_q,
    output wk_time_t now_d
);

    always_comb begin
        if (load)           now_d = load_t;
        else if (sec_pulse) now_d = advance(now_q);
        else                now_d = now_q;
    end

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_d;
    end

    // R2
    clock_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(now_q.day) < DAYS && int'(now_q.hr) < HOURS &&
        int'(now_q.mn) < MINS && int'(now_q.sc) < SECS);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> now_q == $past(load_t));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load && !sec_pulse |=> $stable(now_q));

    // R2
    sec_move_chk: assert property (@(posedge clk) disable iff (rst)
        !load && sec_pulse |=> now_q != $past(now_q));

endmodule

// File: rtl/wkc_remain.sv
module wkc_remain
    import wkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wk_time_t   now_d,
    output wk_remain_t rem_q
);

    wk_remain_t rem_d;

    always_comb rem_d = remaining(now_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            rem_q.off <= 1'b1;
        end else begin
            rem_q <= rem_d;
        end
    end

    // R7
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rem_q.off |-> rem_q.left == '0);

    // R5
    left_range_chk: assert property (@(posedge clk) disable iff (rst)
        !rem_q.off |-> (rem_q.left != '0) && int'(rem_q.left.sc) < SECS &&
                       int'(rem_q.left.mn) < MINS && int'(rem_q.left.hr) < HOURS &&
                       int'(rem_q.left.day) <= CLOSE_DAY);

endmodule

// File: rtl/wk_countdown.sv
module wk_countdown
    import wkc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             set_en,
    input  logic [DAY_W-1:0] set_day,
    input  logic [HR_W-1:0]  set_hr,
    input  logic [MIN_W-1:0] set_min,
    input  logic [SEC_W-1:0] set_sec,
    output logic [DAY_W-1:0] cur_day,
    output logic [HR_W-1:0]  cur_hr,
    output logic [MIN_W-1:0] cur_min,
    output logic [SEC_W-1:0] cur_sec,
    output logic [DAY_W-1:0] rem_day,
    output logic [HR_W-1:0]  rem_hr,
    output logic [MIN_W-1:0] rem_min,
    output logic [SEC_W-1:0] rem_sec,
    output logic             weekend
);

    wk_time_t   set_t;
    wk_time_t   now_q;
    wk_time_t   now_d;
    wk_remain_t rem_q;
    logic       load;
    logic       sec_pulse;

    assign set_t = '{day: set_day, hr: set_hr, mn: set_min, sc: set_sec};
    assign load  = set_en && time_ok(set_t);

    wkc_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) phase_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .load      (load),
        .sec_pulse (sec_pulse)
    );

    wkc_clock clock_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_t    (set_t),
        .sec_pulse (sec_pulse),
        .now_q     (now_q),
        .now_d     (now_d)
    );

    wkc_remain remain_i (
        .clk   (clk),
        .rst   (rst),
        .now_d (now_d),
        .rem_q (rem_q)
    );

    assign cur_day = now_q.day;
    assign cur_hr  = now_q.hr;
    assign cur_min = now_q.mn;
    assign cur_sec = now_q.sc;
    assign rem_day = rem_q.left.day;
    assign rem_hr  = rem_q.left.hr;
    assign rem_min = rem_q.left.mn;
    assign rem_sec = rem_q.left.sc;
    assign weekend = rem_q.off;

    // R4
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        set_en && !load && !tick_en |=> $stable(now_q));

    // R8
    rem_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(now_q) |-> $stable(rem_q));

endmodule

// File: tb/wk_countdown_tb_top.sv
module wk_countdown_tb_top;

    localparam int TPS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       set_en = 1'b0;
    logic [2:0] set_day = '0;
    logic [4:0] set_hr = '0;
    logic [5:0] set_min = '0;
    logic [5:0] set_sec = '0;
    logic [2:0] cur_day;
    logic [4:0] cur_hr;
    logic [5:0] cur_min;
    logic [5:0] cur_sec;
    logic [2:0] rem_day;
    logic [4:0] rem_hr;
    logic [5:0] rem_min;
    logic [5:0] rem_sec;
    logic       weekend;

    int checks = 0;
    int errors = 0;
    int m_day = 0, m_hr = 0, m_min = 0, m_sec = 0, m_ph = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wk_countdown #(.TICKS_PER_SEC(TPS)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .set_en(set_en),
        .set_day(set_day), .set_hr(set_hr), .set_min(set_min), .set_sec(set_sec),
        .cur_day(cur_day), .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
        .rem_day(rem_day), .rem_hr(rem_hr), .rem_min(rem_min), .rem_sec(rem_sec),
        .weekend(weekend)
    );

    // Reference: seconds since Monday 00:00:00, compared against fixed window ends.
    function automatic logic [42:0] expected();
        int t, r, wk, rd, rh, rm, rs;
        t  = ((m_day * 24 + m_hr) * 60 + m_min) * 60 + m_sec;
        wk = (t < 9 * 3600 || t >= (4 * 24 + 17) * 3600) ? 1 : 0;
        rd = 0; rh = 0; rm = 0; rs = 0;
        if (wk == 0) begin
            r  = (4 * 24 + 17) * 3600 - t;
            rd = r / 86400;
            rh = (r % 86400) / 3600;
            rm = (r % 3600) / 60;
            rs = r % 60;
        end
        return {3'(m_day), 5'(m_hr), 6'(m_min), 6'(m_sec),
                3'(rd), 5'(rh), 6'(rm), 6'(rs), 1'(wk)};
    endfunction

    function automatic logic [42:0] actual();
        return {cur_day, cur_hr, cur_min, cur_sec,
                rem_day, rem_hr, rem_min, rem_sec, weekend};
    endfunction

    task automatic check(input string req);
        logic [42:0] a, e;
        a = actual();
        e = expected();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic model_adv();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0; m_day = (m_day + 1) % 7;
                end
            end
        end
    endtask

    task automatic model_apply(input bit s, input int d, h, mi, se, input bit t);
        if (s && d < 7 && h < 24 && mi < 60 && se < 60) begin
            m_day = d; m_hr = h; m_min = mi; m_sec = se; m_ph = 0;
        end else if (t) begin
            if (m_ph == TPS - 1) begin
                m_ph = 0;
                model_adv();
            end else begin
                m_ph++;
            end
        end
    endtask

    task automatic drive(input bit s, input int d, h, mi, se, input bit t);
        set_en  = s;
        set_day = 3'(d);
        set_hr  = 5'(h);
        set_min = 6'(mi);
        set_sec = 6'(se);
        tick_en = t;
    endtask

    task automatic step(input bit s, input int d, h, mi, se, input bit t);
        @(negedge clk);
        drive(s, d, h, mi, se, t);
        @(negedge clk);
        model_apply(s, d, h, mi, se, t);
        set_en  = 1'b0;
        tick_en = 1'b0;
    endtask

    task automatic tick_sec();
        for (int i = 0; i < TPS; i++) step(0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state");

        // R6: opening instant
        step(1, 0, 8, 59, 59, 0);
        check("R6 Monday 08:59:59 weekend");
        tick_sec();
        check("R6 Monday 09:00:00 countdown");
        if ({rem_day, rem_hr, rem_min, rem_sec} !== {3'd4, 5'd8, 6'd0, 6'd0}) begin
            checks++; errors++;
            $display("FAIL R6 direct actual=%0d/%0d/%0d/%0d expected=4/8/0/0",
                     rem_day, rem_hr, rem_min, rem_sec);
        end else checks++;
        tick_sec();
        check("R5 Monday 09:00:01 borrow");

        // R7: closing instant
        step(1, 4, 16, 59, 59, 0);
        check("R7 Friday 16:59:59 one second left");
        tick_sec();
        check("R7 Friday 17:00:00 weekend zeros");

        // R2: full wrap from last day
        step(1, 6, 23, 59, 59, 0);
        tick_sec();
        check("R2 Sunday wrap to Monday 00:00:00");
        step(1, 2, 23, 59, 59, 0);
        tick_sec();
        check("R2 carry through all fields");

        // R3: set beats tick, clears pulse count
        step(1, 1, 10, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        step(1, 3, 12, 30, 15, 1);
        check("R3 set priority over tick");
        step(0, 0, 0, 0, 0, 1);
        check("R3 pulse count cleared by set");
        step(0, 0, 0, 0, 0, 1);
        check("R3 second after full count");

        // R4: invalid sets ignored, pulse count kept
        step(0, 0, 0, 0, 0, 1);
        step(1, 2, 24, 0, 0, 0);
        check("R4 hour 24 rejected");
        step(1, 7, 1, 0, 0, 0);
        step(1, 1, 1, 60, 0, 0);
        step(1, 1, 1, 0, 63, 0);
        check("R4 day/minute/second out of range rejected");
        step(0, 0, 0, 0, 0, 1);
        check("R4 pulse count survives rejected set");

        // R8: outputs change only at the sampling edge
        @(negedge clk);
        drive(1, 2, 14, 5, 6, 0);
        #1;
        check("R8 unchanged before edge");
        @(negedge clk);
        model_apply(1, 2, 14, 5, 6, 0);
        set_en = 1'b0;
        check("R8 updated after edge");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int k, d, h, mi, se;
            k  = int'($urandom_range(0, 99));
            d  = int'($urandom_range(0, 6));
            h  = int'($urandom_range(0, 23));
            mi = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
            se = ($urandom_range(0, 1) == 1) ? int'($urandom_range(57, 59)) : int'($urandom_range(0, 59));
            if (k < 3) begin
                case ($urandom_range(0, 3))
                    0: d  = 7;
                    1: h  = int'($urandom_range(24, 31));
                    2: mi = int'($urandom_range(60, 63));
                    default: se = int'($urandom_range(60, 63));
                endcase
                step(1, d, h, mi, se, $urandom_range(0, 1) == 1);
                check("R4 random rejected set");
            end else if (k < 10) begin
                step(1, d, h, mi, se, $urandom_range(0, 1) == 1);
                check("R3 random set");
            end else begin
                step(0, 0, 0, 0, 0, $urandom_range(0, 9) < 7);
                check("R5 random tick");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule